// File: doc/BRIEF.md
# Exposure Shutter Controller

This block sets the exposure of an image sensor by timing two strobes: a discharge pulse, which empties the photo sites, and a readout gate, which moves the collected charge into the vertical transfer path. It runs from a line-rate strobe and a field-start strobe. A 9-bit load value sets the exposure. It has two ways of working. In normal operation the readout gate fires at each field start. A high-speed setting sets the exposure in whole lines by discharging on the early lines of the field. A low-speed setting stretches the exposure over several fields by skipping readouts.

In random-trigger operation the sensor discharges on every line and no readout happens. A falling edge on the trigger input starts the exposure. It issues a line-timing reset, which also restarts the vertical clocks and the clamp and blanking pulses downstream, and one last discharge pulse. After the programmed number of lines it issues the readout gate together with a write-enable marker for frame memory. While this mode is selected, the block flags that vertical sync generation is halted.

All outputs are registered one-cycle pulses. Each appears in the cycle after the strobe that causes it.

Top module: `shutter_ctrl`

## Requirements
- R1: After reset, all outputs are low.
- R2: With `mode_i`=2'b00 (high-speed), the exposure is E = 262 − (0x1FF − L) lines. Field lines are numbered from 0 at the field strobe, and `sub_o` pulses on each line whose index is below 262 − E.
- R3: A high-speed load value that gives E < 1 is clamped to E = 1, so `sub_o` pulses on lines 0 to 260.
- R4: In normal operation with `mode_i` = 2'b00, 2'b10 or 2'b11, `sg_o` and `wen_o` pulse for one cycle after every field strobe.
- R5: With `mode_i`=2'b10 or 2'b11 (shutter off) or 2'b01, `sub_o` never pulses in normal operation.
- R6: With `mode_i`=2'b01 (low-speed), `sg_o` and `wen_o` pulse only on every N-th field strobe, where N = 2 × (0x1FF − L). Counting starts at the first field strobe after entering the mode.
- R7: A low-speed load value of 0x1FF, which would give N = 0, is clamped to N = 2.
- R8: With `rnd_en_i` high and no exposure running, `sub_o` pulses on every line strobe and `sg_o` stays low.
- R9: A falling edge on `trig_i` while idle produces a one-cycle `line_rst_o` pulse together with a `sub_o` pulse. After that, `sub_o` stays low for the whole exposure.
- R10: On the E-th line strobe after the trigger, with E from the R2/R3 formula, `sg_o` and `wen_o` pulse together and the block returns to idle.
- R11: A trigger edge during a running exposure produces no line reset and does not move the readout.
- R12: While `rnd_en_i` is high, `vsync_halt_o` is high and field strobes cause no readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_stb_i | input | 1 | One-cycle pulse per line |
| field_stb_i | input | 1 | Field start, valid together with `line_stb_i` |
| mode_i | input | 2 | 00 high-speed, 01 low-speed, 1x off |
| rnd_en_i | input | 1 | Random-trigger operation |
| load_i | input | 9 | Shutter load value |
| trig_i | input | 1 | External trigger, acts on its falling edge |
| sub_o | output | 1 | Discharge pulse |
| sg_o | output | 1 | Readout gate pulse |
| wen_o | output | 1 | Frame-write start marker |
| line_rst_o | output | 1 | Forced line-timing reset |
| vsync_halt_o | output | 1 | Vertical sync generation halted |

## Verification
The bench counts discharge pulses across a full field for a mid-range load and for a load below the clamp point. A design that wraps the signed exposure term would discharge on the wrong number of lines, or on none. In low-speed mode it locates readouts across several fields, including the zero-field load: a missing clamp never reads out, and an off-by-one counter reads out one field early. In random-trigger mode it checks that the trigger gives exactly one discharge and one line reset, that the readout lands on the third line for a three-line exposure, and that a second trigger inside the exposure changes nothing. A design that restarts the count on that second edge would read out late.

// File: rtl/shutter_pkg.sv
package shutter_pkg;
  typedef enum logic [1:0] {
    SHM_HIGH = 2'b00,
    SHM_LOW  = 2'b01,
    SHM_OFF  = 2'b10,
    SHM_OFF2 = 2'b11
  } shm_e;

  localparam int unsigned LOAD_W   = 9;
  localparam int unsigned LOAD_MAX = (1 << LOAD_W) - 1;
endpackage

// File: rtl/shutter_load_dec.sv
module shutter_load_dec import shutter_pkg::*; #(
  parameter int unsigned FIELD_LINES = 262,
  parameter int unsigned EXP_BASE    = 262,
  parameter int unsigned LW          = $clog2(FIELD_LINES + 1),
  parameter int unsigned FW          = LOAD_W + 1
) (
  input  logic [LOAD_W-1:0] load_i,
  output logic [LW-1:0]     exp_lines_o,
  output logic [FW-1:0]     exp_fields_o
);
  int raw_lines;
  logic [FW-1:0] raw_fields;

  always_comb begin
    raw_lines = int'(EXP_BASE) - int'(LOAD_MAX) + int'(load_i);
    if (raw_lines < 1)                     exp_lines_o = LW'(1);
    else if (raw_lines > int'(FIELD_LINES)) exp_lines_o = LW'(FIELD_LINES);
    else                                   exp_lines_o = LW'(raw_lines);

    raw_fields   = FW'(LOAD_MAX - int'(load_i)) << 1;
    exp_fields_o = (raw_fields == '0) ? FW'(2) : raw_fields;
  end
endmodule

// File: rtl/shutter_normal.sv
module shutter_normal import shutter_pkg::*; #(
  parameter int unsigned FIELD_LINES = 262,
  parameter int unsigned LW          = $clog2(FIELD_LINES + 1),
  parameter int unsigned FW          = LOAD_W + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_stb_i,
  input  logic          field_stb_i,
  input  shm_e          mode_i,
  input  logic [LW-1:0] exp_lines_i,
  input  logic [FW-1:0] exp_fields_i,
  output logic          sub_o,
  output logic          sg_o
);
  logic [LW-1:0] line_q, line_d, thresh;
  logic [FW-1:0] fcnt_q, fcnt_d;
  logic          fld, low_hit;

  always_comb begin
    thresh = LW'(FIELD_LINES) - exp_lines_i;
    if (field_stb_i)                          line_d = '0;
    else if (line_q == LW'(FIELD_LINES - 1))  line_d = line_q;
    else                                      line_d = line_q + LW'(1);
    fld     = line_stb_i && field_stb_i;
    low_hit = ({1'b0, fcnt_q} + (FW+1)'(1)) >= {1'b0, exp_fields_i};
    sub_o   = line_stb_i && (mode_i == SHM_HIGH) && (line_d < thresh);
    sg_o    = fld && ((mode_i != SHM_LOW) || low_hit);
    if (mode_i != SHM_LOW) fcnt_d = '0;
    else if (fld)          fcnt_d = low_hit ? '0 : fcnt_q + FW'(1);
    else                   fcnt_d = fcnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      fcnt_q <= '0;
    end else begin
      if (line_stb_i) line_q <= line_d;
      fcnt_q <= fcnt_d;
    end
  end

  AST_LINE_IN_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q < LW'(FIELD_LINES)); // R2
  AST_FCNT_BELOW_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SHM_LOW && $stable(exp_fields_i) && $stable(mode_i)) |-> fcnt_q < exp_fields_i); // R6
endmodule

// File: rtl/shutter_trig.sv
module shutter_trig #(
  parameter int unsigned LW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          line_stb_i,
  input  logic          trig_i,
  input  logic [LW-1:0] exp_lines_i,
  output logic          sub_o,
  output logic          sg_o,
  output logic          line_rst_o
);
  typedef enum logic {ST_IDLE, ST_EXP} st_e;
  st_e           st_q, st_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          trig_q, fall;

  always_comb begin
    fall       = en_i && trig_q && !trig_i;
    st_d       = st_q;
    cnt_d      = cnt_q;
    sub_o      = 1'b0;
    sg_o       = 1'b0;
    line_rst_o = 1'b0;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else if (st_q == ST_IDLE) begin
      sub_o = line_stb_i || fall;
      if (fall) begin
        line_rst_o = 1'b1;
        cnt_d      = exp_lines_i;
        st_d       = ST_EXP;
      end
    end else if (line_stb_i) begin
      if (cnt_q <= LW'(1)) begin
        sg_o = 1'b1;
        st_d = ST_IDLE;
      end else begin
        cnt_d = cnt_q - LW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      trig_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      trig_q <= trig_i;
    end
  end

  AST_EXP_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_EXP |-> cnt_q != '0); // R10
  AST_SG_ENDS_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_o |=> st_q == ST_IDLE); // R10
endmodule

// File: rtl/shutter_ctrl.sv
module shutter_ctrl import shutter_pkg::*; #(
  parameter int unsigned FIELD_LINES = 262,
  parameter int unsigned EXP_BASE    = 262
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_stb_i,
  input  logic       field_stb_i,
  input  logic [1:0] mode_i,
  input  logic       rnd_en_i,
  input  logic [8:0] load_i,
  input  logic       trig_i,
  output logic       sub_o,
  output logic       sg_o,
  output logic       wen_o,
  output logic       line_rst_o,
  output logic       vsync_halt_o
);
  localparam int unsigned LW = $clog2(FIELD_LINES + 1);
  localparam int unsigned FW = LOAD_W + 1;

  logic [LW-1:0] exp_lines;
  logic [FW-1:0] exp_fields;
  logic n_sub, n_sg, t_sub, t_sg, t_rst;

  shutter_load_dec #(.FIELD_LINES(FIELD_LINES), .EXP_BASE(EXP_BASE), .LW(LW), .FW(FW)) i_dec (
    .load_i(load_i), .exp_lines_o(exp_lines), .exp_fields_o(exp_fields)
  );

  shutter_normal #(.FIELD_LINES(FIELD_LINES), .LW(LW), .FW(FW)) i_norm (
    .clk_i, .rst_ni, .line_stb_i, .field_stb_i,
    .mode_i(shm_e'(mode_i)), .exp_lines_i(exp_lines), .exp_fields_i(exp_fields),
    .sub_o(n_sub), .sg_o(n_sg)
  );

  shutter_trig #(.LW(LW)) i_trig (
    .clk_i, .rst_ni, .en_i(rnd_en_i), .line_stb_i, .trig_i,
    .exp_lines_i(exp_lines), .sub_o(t_sub), .sg_o(t_sg), .line_rst_o(t_rst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_o        <= 1'b0;
      sg_o         <= 1'b0;
      wen_o        <= 1'b0;
      line_rst_o   <= 1'b0;
      vsync_halt_o <= 1'b0;
    end else begin
      sub_o        <= rnd_en_i ? t_sub : n_sub;
      sg_o         <= rnd_en_i ? t_sg  : n_sg;
      wen_o        <= rnd_en_i ? t_sg  : n_sg;
      line_rst_o   <= rnd_en_i && t_rst;
      vsync_halt_o <= rnd_en_i;
    end
  end

  AST_RST_WITH_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_rst_o |-> sub_o && !sg_o); // R9
  AST_WEN_MATCHES_SG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wen_o) |-> $rose(sg_o)); // R10
endmodule

// File: tb/test_shutter_ctrl.sv
module test_shutter_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_stb = 1'b0, field_stb = 1'b0, rnd_en = 1'b0, trig = 1'b0;
  logic [1:0] mode = 2'b10;
  logic [8:0] load = 9'h1FF;
  logic sub, sg, wen, lrst, vhalt;
  int checks = 0, errors = 0;
  int n_sub, n_sg, n_wen, last_sub;

  always #4 clk = ~clk;

  shutter_ctrl i_shutter_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .line_stb_i(line_stb), .field_stb_i(field_stb),
    .mode_i(mode), .rnd_en_i(rnd_en), .load_i(load), .trig_i(trig),
    .sub_o(sub), .sg_o(sg), .wen_o(wen), .line_rst_o(lrst), .vsync_halt_o(vhalt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input bit fld);
    @(negedge clk); line_stb = 1'b1; field_stb = fld;
    @(negedge clk); line_stb = 1'b0; field_stb = 1'b0;
  endtask

  task automatic run_field();
    n_sub = 0; n_sg = 0; n_wen = 0; last_sub = -1;
    for (int i = 0; i < 262; i++) begin
      strobe(i == 0);
      if (sub) begin n_sub++; last_sub = i; end
      if (sg) n_sg++;
      if (wen) n_wen++;
    end
  endtask

  task automatic t_reset();
    chk({sub, sg, wen, lrst, vhalt} == 5'b0, "R1 reset outputs", int'({sub, sg, wen, lrst, vhalt}), 0);
  endtask

  task automatic t_high();
    mode = 2'b00; load = 9'h1F0;  // E = 247, discharge lines 0..14
    run_field();
    chk(n_sub == 15, "R2 sub count", n_sub, 15);
    chk(last_sub == 14, "R2 last sub line", last_sub, 14);
    chk(n_sg == 1 && n_wen == 1, "R4 one readout per field", n_sg + n_wen, 2);
    load = 9'h0F0;  // would be negative -> E = 1
    run_field();
    chk(n_sub == 261, "R3 clamped sub count", n_sub, 261);
  endtask

  task automatic t_off();
    mode = 2'b10;
    run_field();
    chk(n_sub == 0, "R5 off no sub", n_sub, 0);
    chk(n_sg == 1 && n_wen == 1, "R4 off readout", n_sg + n_wen, 2);
  endtask

  task automatic t_low(input logic [8:0] l, input int n);
    int hits, first;
    mode = 2'b10; @(negedge clk);
    mode = 2'b01; load = l;
    hits = 0; first = -1; n_sub = 0;
    for (int f = 0; f < 2 * n; f++) begin
      strobe(1'b1);
      if (sg && wen) begin hits++; if (first < 0) first = f; end
      if (sub) n_sub++;
    end
    if (l == 9'h1FF) begin
      chk(hits == 2, "R7 clamped readouts", hits, 2);
      chk(first == 1, "R7 first readout field", first, 1);
    end else begin
      chk(hits == 2, "R6 readouts", hits, 2);
      chk(first == n - 1, "R6 first readout field", first, n - 1);
    end
    chk(n_sub == 0, "R5 low-speed no sub", n_sub, 0);
  endtask

  task automatic t_random();
    mode = 2'b00; load = 9'h0FC; rnd_en = 1'b1;  // E = 3
    @(negedge clk);
    chk(vhalt == 1'b1, "R12 vsync halted", vhalt, 1);
    strobe(1'b0);
    chk(sub && !sg, "R8 idle discharge", int'({sub, sg}), 2);
    strobe(1'b1);
    chk(sub && !sg && !wen, "R12 field strobe no readout", int'({sub, sg, wen}), 4);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    @(negedge clk);
    chk(lrst && sub, "R9 line reset and last sub", int'({lrst, sub}), 3);
    @(negedge clk);
    chk(!lrst && !sub, "R9 single pulse", int'({lrst, sub}), 0);
    strobe(1'b0);
    chk(!sub && !sg, "R9 no sub line 1", int'({sub, sg}), 0);
    trig = 1'b1; @(negedge clk); trig = 1'b0; @(negedge clk);
    chk(!lrst, "R11 retrigger ignored", lrst, 0);
    strobe(1'b0);
    chk(!sub && !sg, "R11 no readout line 2", int'({sub, sg}), 0);
    strobe(1'b0);
    chk(sg && wen && !sub, "R10 readout line 3", int'({sg, wen, sub}), 6);
    strobe(1'b0);
    chk(sub && !sg, "R10 back to idle", int'({sub, sg}), 2);
    rnd_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_high();
    t_off();
    t_low(9'h1FD, 4);
    t_low(9'h1FF, 2);
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule